// File: doc/BRIEF.md
# Bank Chip-Select Address Decoder

This block sits between a 32-bit bus master and a set of external memories that share one 27-bit address bus. It splits each bus address into a bank number and an in-bank offset. For an address in one of the eight 128 MB banks it pulls exactly one active-low chip select low. Together the banks fill the lowest 1 GB of the address space. Above that window, one address range is claimed by the on-chip register block. Every other address is reported as a decode error and selects nothing.

A boot-mode strap changes how the bottom of the map is decoded. With the strap low, bank 0 is an ordinary external linear flash and decodes like any other bank. With the strap high, the first 4 KB at address zero is served by an internal boot SRAM, and bank 0's external select never asserts. The rest of bank 0 then counts as unused space.

All outputs are registered, so every decision appears exactly one clock after the address and valid strobe are presented.

Top module: `bank_cs_decoder`

## Requirements
- R1: While reset is held low at a clock edge, the outputs settle to their idle values on that edge: all chip selects high, and `sram_sel`, `reg_sel` and `dec_err` low.
- R2: The outputs reflect the inputs sampled at the previous rising edge. When `bus_valid` was low, every select is idle and `dec_err` is low.
- R3: A valid address below 0x4000_0000 whose bits [29:27] equal n (n from 1 to 7) drives `cs_n[n]` low, and only that bit. Bank n therefore starts at n × 0x0800_0000; for example, 0x3000_0000 selects bank 6.
- R4: After a valid access, `bank_offset` equals address bits [26:0]. After an invalid cycle, it keeps its previous value.
- R5: Among the eight selects, `sram_sel`, `reg_sel` and `dec_err`, at most one is active at any time.
- R6: With `boot_nand` high, a valid address from 0x0000_0000 to 0x0000_0FFF asserts `sram_sel` and leaves `cs_n[0]` high.
- R7: With `boot_nand` high, a valid address from 0x0000_1000 to 0x07FF_FFFF raises `dec_err` and asserts no select.
- R8: With `boot_nand` low, any valid address from 0x0000_0000 to 0x07FF_FFFF drives `cs_n[0]` low.
- R9: A valid address from 0x4800_0000 to 0x5FFF_FFFF inclusive asserts `reg_sel`.
- R10: A valid address at or above 0x4000_0000 that is outside the register range raises `dec_err` and asserts no select.
- R11: Decoding of banks 1 to 7 is the same under both boot modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | High when `bus_addr` carries an access |
| bus_addr | input | 32 | Byte address from the bus master |
| boot_nand | input | 1 | Boot strap: 1 = internal boot SRAM at address zero, 0 = external flash in bank 0 |
| cs_n | output | 8 | Active-low bank selects; bit n is bank n |
| sram_sel | output | 1 | Internal boot SRAM selected |
| reg_sel | output | 1 | Internal register region selected |
| dec_err | output | 1 | Access hit unused address space |
| bank_offset | output | 27 | In-bank offset of the last valid access |

## Verification
The hardest cases sit on the narrow edges of the map. These are the last byte of the 4 KB boot window against the first byte after it, and the two ends of the register range next to the error space that surrounds it. Uniform random 32-bit addresses almost never land on these edges, and they hit the boot window only about once in a million draws. The stimulus therefore draws from weighted classes: the boot window, the bottom of bank 0, each bank, the register range, and the error ranges. It flips the strap at random, and adds directed accesses on each boundary byte under both strap settings.

// File: rtl/bank_cs_pkg.sv
// Shared types for the bank chip-select decoder.
// Assumes: the consumers need only the region class of an access.
package bank_cs_pkg;
    typedef enum logic [2:0] {
        RG_NONE      = 3'd0,
        RG_BANK      = 3'd1,
        RG_BOOT_SRAM = 3'd2,
        RG_REGS      = 3'd3,
        RG_ERR       = 3'd4
    } region_e;
endpackage

// File: rtl/bank_addr_classify.sv
// Sorts a bus address into a region class and extracts the bank index.
// Assumes: the bank window starts at zero and is NUM_BANKS << OFFS_W bytes.
// The register range lies wholly above that window.
module bank_addr_classify
    import bank_cs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFFS_W     = 27,
    parameter int NUM_BANKS  = 8,
    parameter int BOOT_BYTES = 4096,
    parameter logic [ADDR_W-1:0] REG_LO = 32'h4800_0000,
    parameter logic [ADDR_W-1:0] REG_HI = 32'h5FFF_FFFF,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_nand,
    output region_e           region,
    output logic [BANK_W-1:0] bank_idx
);
    localparam logic [ADDR_W:0] WIN_END  = (ADDR_W+1)'(NUM_BANKS) << OFFS_W;
    localparam logic [ADDR_W:0] BOOT_END = (ADDR_W+1)'(BOOT_BYTES);

    logic in_window;
    logic in_boot;
    logic in_regs;

    // Range comparators on the raw address.
    always_comb begin
        in_window = {1'b0, addr} < WIN_END;
        in_boot   = {1'b0, addr} < BOOT_END;
        in_regs   = (addr >= REG_LO) && (addr <= REG_HI);
        bank_idx  = addr[OFFS_W +: BANK_W];
    end

    // Region priority: idle, bank window (with boot remap of bank 0), registers, error.
    always_comb begin
        region = RG_NONE;
        if (valid) begin
            if (in_window) begin
                if (boot_nand && (bank_idx == '0))
                    region = in_boot ? RG_BOOT_SRAM : RG_ERR;
                else
                    region = RG_BANK;
            end else if (in_regs) begin
                region = RG_REGS;
            end else begin
                region = RG_ERR;
            end
        end
    end
endmodule

// File: rtl/bank_sel_expand.sv
// Expands a region class and bank index into select strobes.
// Assumes: bank_idx matters only when the region is RG_BANK.
module bank_sel_expand
    import bank_cs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  region_e              region,
    input  logic [BANK_W-1:0]    bank_idx,
    output logic [NUM_BANKS-1:0] cs_n_d,
    output logic                 sram_d,
    output logic                 reg_d,
    output logic                 err_d
);
    // One active-low select per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
        assign cs_n_d[g] = !((region == RG_BANK) && (bank_idx == BANK_W'(g)));
    end

    // Strobes for the internal targets and the error flag.
    always_comb begin
        sram_d = (region == RG_BOOT_SRAM);
        reg_d  = (region == RG_REGS);
        err_d  = (region == RG_ERR);
    end
endmodule

// File: rtl/bank_cs_decoder.sv
// Top of the bank chip-select decoder. Classifies the address, expands the
// result into select strobes and registers every output, giving a fixed
// one-cycle latency.
// Assumes: a synchronous active-low reset; inputs are stable around the rising edge.
module bank_cs_decoder
    import bank_cs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFFS_W     = 27,
    parameter int NUM_BANKS  = 8,
    parameter int BOOT_BYTES = 4096,
    parameter logic [ADDR_W-1:0] REG_LO = 32'h4800_0000,
    parameter logic [ADDR_W-1:0] REG_HI = 32'h5FFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 boot_nand,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic                 sram_sel,
    output logic                 reg_sel,
    output logic                 dec_err,
    output logic [OFFS_W-1:0]    bank_offset
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    region_e              region;
    logic [BANK_W-1:0]    bank_idx;
    logic [NUM_BANKS-1:0] cs_n_d;
    logic                 sram_d;
    logic                 reg_d;
    logic                 err_d;

    bank_addr_classify #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .NUM_BANKS(NUM_BANKS),
        .BOOT_BYTES(BOOT_BYTES), .REG_LO(REG_LO), .REG_HI(REG_HI)
    ) u_classify (
        .valid(bus_valid), .addr(bus_addr), .boot_nand(boot_nand),
        .region(region), .bank_idx(bank_idx)
    );

    bank_sel_expand #(.NUM_BANKS(NUM_BANKS)) u_expand (
        .region(region), .bank_idx(bank_idx),
        .cs_n_d(cs_n_d), .sram_d(sram_d), .reg_d(reg_d), .err_d(err_d)
    );

    // Output registers: the selects go idle in reset and follow the decode otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n     <= '1;
            sram_sel <= 1'b0;
            reg_sel  <= 1'b0;
            dec_err  <= 1'b0;
        end else begin
            cs_n     <= cs_n_d;
            sram_sel <= sram_d;
            reg_sel  <= reg_d;
            dec_err  <= err_d;
        end
    end

    // Offset register: captures the low address bits on valid accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_offset <= '0;
        else if (bus_valid)
            bank_offset <= bus_addr[OFFS_W-1:0];
    end

    // R5: never more than one target or error flagged.
    p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~cs_n, sram_sel, reg_sel, dec_err}) <= 1);

    // R2: an idle bus cycle yields idle outputs on the next edge.
    p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (&cs_n && !sram_sel && !reg_sel && !dec_err));

    // R6: the boot window goes to the internal SRAM, never to bank 0.
    p_boot_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && boot_nand && ({1'b0, bus_addr} < (ADDR_W+1)'(BOOT_BYTES)))
        |=> (sram_sel && cs_n[0]));

    // R9: register range hits raise reg_sel.
    p_reg_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr >= REG_LO && bus_addr <= REG_HI) |=> reg_sel);

    // R4: the offset holds across idle cycles.
    p_offset_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && $past(rst_n)) |=> $stable(bank_offset));
endmodule

// File: tb/tb_bank_cs_decoder.sv
module tb_bank_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        boot_nand = 1'b0;
    logic [7:0]  cs_n;
    logic        sram_sel, reg_sel, dec_err;
    logic [26:0] bank_offset;

    int checks = 0;
    int errors = 0;
    logic [26:0] exp_off = '0;

    always #10 clk = ~clk;

    bank_cs_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .boot_nand(boot_nand), .cs_n(cs_n), .sram_sel(sram_sel),
        .reg_sel(reg_sel), .dec_err(dec_err), .bank_offset(bank_offset)
    );

    // Expected {cs_n, sram_sel, reg_sel, dec_err} from the requirements.
    function automatic logic [10:0] model(input logic v, input logic [31:0] a, input logic nb);
        logic [7:0] c;
        c = 8'hFF;
        if (!v) return {c, 3'b000};
        if (a < 32'h4000_0000) begin
            if (a[29:27] == 3'd0 && nb)
                return (a < 32'h1000) ? {c, 3'b100} : {c, 3'b001};
            c[a[29:27]] = 1'b0;
            return {c, 3'b000};
        end
        if (a >= 32'h4800_0000 && a <= 32'h5FFF_FFFF) return {c, 3'b010};
        return {c, 3'b001};
    endfunction

    function automatic string tag(input logic v, input logic [31:0] a, input logic nb);
        if (!v) return "R2";
        if (a < 32'h0800_0000) return nb ? ((a < 32'h1000) ? "R6" : "R7") : "R8";
        if (a < 32'h4000_0000) return "R3/R11";
        if (a >= 32'h4800_0000 && a <= 32'h5FFF_FFFF) return "R9";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge and check at the next falling edge (one register stage).
    task automatic access(input logic v, input logic [31:0] a, input logic nb);
        logic [10:0] e;
        bus_valid = v; bus_addr = a; boot_nand = nb;
        e = model(v, a, nb);
        if (v) exp_off = a[26:0];
        @(negedge clk);
        check(tag(v, a, nb), 32'({cs_n, sram_sel, reg_sel, dec_err}), 32'(e));
        check("R4", 32'(bank_offset), 32'(exp_off));
        check("R5", 32'($countones({~cs_n, sram_sel, reg_sel, dec_err}) <= 1), 32'd1);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        bus_valid = 1'b1; bus_addr = 32'h3000_0000;
        repeat (3) @(negedge clk);
        // R1: idle outputs while reset is held, even with a valid access presented.
        check("R1", 32'({cs_n, sram_sel, reg_sel, dec_err}), 32'({8'hFF, 3'b000}));
        check("R1", 32'(bank_offset), 32'd0);
        rst_n = 1'b1;

        // Directed boundary cases.
        access(1, 32'h0000_0000, 1);   // R6
        access(1, 32'h0000_0FFF, 1);   // R6
        access(1, 32'h0000_1000, 1);   // R7
        access(1, 32'h07FF_FFFF, 1);   // R7
        access(1, 32'h0000_0000, 0);   // R8
        access(1, 32'h07FF_FFFF, 0);   // R8
        access(1, 32'h0800_0000, 1);   // R3 R11
        access(1, 32'h3000_0000, 0);   // R3 bank 6
        access(1, 32'h3000_0000, 1);   // R11
        access(1, 32'h3FFF_FFFF, 0);   // R3 bank 7
        access(1, 32'h4000_0000, 0);   // R10
        access(1, 32'h47FF_FFFF, 0);   // R10
        access(1, 32'h4800_0000, 0);   // R9
        access(1, 32'h5FFF_FFFF, 1);   // R9
        access(1, 32'h6000_0000, 0);   // R10
        access(1, 32'hFFFF_FFFF, 1);   // R10
        access(0, 32'h0000_0010, 1);   // R2 and R4 hold
        access(0, 32'h3000_0000, 0);   // R2

        // Weighted random classes.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic v, nb;
            int k;
            k  = int'($urandom_range(0, 6));
            nb = 1'($urandom);
            v  = ($urandom_range(0, 7) != 0);
            case (k)
                0: a = $urandom_range(0, 32'h1FFF);
                1: a = {5'b0, 27'($urandom)};
                2: a = {2'b00, 30'($urandom)};
                3: a = $urandom_range(32'h4800_0000, 32'h5FFF_FFFF);
                4: a = $urandom_range(32'h4000_0000, 32'h4800_0FFF);
                5: a = $urandom_range(32'h5FFF_F000, 32'h6000_0FFF);
                default: a = $urandom;
            endcase
            access(v, a, nb);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule